// File: doc/BRIEF.md
# Global Address Chip-Select Decoder

This block turns a 23-bit global bus address into four active-low external chip selects. Each chip select owns a fixed address window. It fires one clock after a valid access that lands in its window, but only if two conditions hold. Its 2-bit enable field in a byte-wide control register must be non-zero. The device must also be running in one of the two expanded operating modes. The control register is written and read back through a small register port.

Two elaboration parameters size the on-chip RAM and flash, and they cut the tops of the lowest and highest windows. The lowest window loses the RAM size from its ceiling. The highest window loses the flash size from its ceiling, but only while the on-chip flash is switched on. A separate hide input lends a parameterised on-chip region to chip select 2, so that external memory can stand in for it.

Top module: `gcs_decoder`

## Requirements
- R1: The control register is read back unchanged on `reg_rdata_o`. Its bit pairs [7:6], [5:4], [3:2] and [1:0] are the enable fields of chip selects 3, 2, 1 and 0, in that order.
- R2: An enable field of 2'b00 keeps its chip select inactive. A field of 2'b01, 2'b10 or 2'b11 lets it assert.
- R3: Chip selects can assert only when `mode_i` is 3'b011 (emulation expanded) or 3'b101 (normal expanded). For every other mode value all outputs stay high.
- R4: Chip select 3 (`cs_n_o[3]`) decodes addresses from 0x000800 up to 0x0FFFFF minus RAM_BYTES, with both ends inclusive.
- R5: Chip select 2 (`cs_n_o[2]`) decodes 0x140000 through 0x1FFFFF.
- R6: While `rom_hide_i` is 1, chip select 2 also decodes HIDE_BASE through HIDE_BASE+HIDE_BYTES-1.
- R7: Chip select 1 (`cs_n_o[1]`) decodes 0x200000 through 0x3FFFFF.
- R8: While `nvm_on_i` is 1, chip select 0 (`cs_n_o[0]`) decodes 0x400000 through 0x7FFFFF minus FLASH_BYTES, and it stays inactive above that address.
- R9: While `nvm_on_i` is 0, chip select 0 decodes 0x400000 through 0x7FFFFF.
- R10: The outputs are active low and registered. Each one reflects the access presented in the previous cycle. A cycle with `acc_valid_i` low gives all-high outputs, and at most one output is low at a time.
- R11: A synchronous reset clears the register to 0x00 and drives all outputs high. A write takes effect at the next clock edge, so an access in the same cycle as a write is decoded with the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode code |
| rom_hide_i | input | 1 | Hands the hideable on-chip region to chip select 2 |
| nvm_on_i | input | 1 | On-chip flash enabled; trims the chip select 0 window |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| acc_valid_i | input | 1 | External access strobe |
| acc_addr_i | input | 23 | Global access address |
| cs_n_o | output | 4 | Active-low chip selects, bit n is chip select n |

## Verification
Every window is probed at four addresses: one below its bottom, its bottom, its top, and one above its top. This separates off-by-one errors at each inclusive edge, and it shows whether the RAM and flash trims move the right edge. The sweep runs under all eight mode codes and all four hide and flash settings. It covers enable patterns that leave some fields at 00 and set others to each of 01, 10 and 11. This tells a mode or field gating fault apart from a window fault. Idle cycles and same-cycle write plus access patterns check the registered, old-value timing.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int GA_W    = 23;
    localparam int NUM_CS  = 4;
    localparam int FIELD_W = 2;
    localparam int CTRL_W  = NUM_CS * FIELD_W;

    typedef enum logic [2:0] {
        MODE_SPEC_SINGLE = 3'd0,
        MODE_EMU_SINGLE  = 3'd1,
        MODE_SPEC_TEST   = 3'd2,
        MODE_EMU_EXP     = 3'd3,
        MODE_NORM_SINGLE = 3'd4,
        MODE_NORM_EXP    = 3'd5,
        MODE_RSVD_6      = 3'd6,
        MODE_RSVD_7      = 3'd7
    } op_mode_e;

    // fixed window limits of the global map
    localparam int unsigned CS3_LO   = 32'h0000_0800;
    localparam int unsigned CS3_CEIL = 32'h000F_FFFF;
    localparam int unsigned CS2_LO   = 32'h0014_0000;
    localparam int unsigned CS2_HI   = 32'h001F_FFFF;
    localparam int unsigned CS1_LO   = 32'h0020_0000;
    localparam int unsigned CS1_HI   = 32'h003F_FFFF;
    localparam int unsigned CS0_LO   = 32'h0040_0000;
    localparam int unsigned CS0_CEIL = 32'h007F_FFFF;

    typedef struct packed {
        logic            valid;
        logic [GA_W-1:0] addr;
    } bus_acc_t;

    typedef struct packed {
        logic hide;
        logic nvm;
        logic expanded;
    } mode_ctl_t;

    function automatic logic mode_is_expanded(input logic [2:0] m);
        return (m == MODE_EMU_EXP) || (m == MODE_NORM_EXP);
    endfunction

    function automatic int unsigned win_lo(input int idx);
        case (idx)
            3:       return CS3_LO;
            2:       return CS2_LO;
            1:       return CS1_LO;
            default: return CS0_LO;
        endcase
    endfunction

    // window top with the on-chip memory trims applied
    function automatic int unsigned win_hi(input int idx, input int unsigned ram_b,
                                           input int unsigned flash_b);
        case (idx)
            3:       return CS3_CEIL - ram_b;
            2:       return CS2_HI;
            1:       return CS1_HI;
            default: return CS0_CEIL - flash_b;
        endcase
    endfunction

endpackage

// File: rtl/gcs_ctrl_reg.sv
module gcs_ctrl_reg
    import gcs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] q_o,
    output logic [NUM_CS-1:0] en_o
);

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q <= wdata_i;
        end
    end

    assign q_o = ctrl_q;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_field
        assign en_o[i] = |ctrl_q[FIELD_W*i +: FIELD_W];
    end

    assert_reset_clear_R11: assert property (@(posedge clk_i)
        rst_i |=> (q_o == '0));

    assert_write_lands_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i |=> (q_o == $past(wdata_i)));

    assert_hold_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_i |=> $stable(q_o));

endmodule

// File: rtl/gcs_window.sv
module gcs_window
    import gcs_pkg::*;
#(
    parameter int unsigned LO = 32'h0,
    parameter int unsigned HI = 32'h0
) (
    input  logic [GA_W-1:0] addr_i,
    output logic            hit_o
);

    logic [31:0] addr_w;

    assign addr_w = 32'(addr_i);
    assign hit_o  = (addr_w >= LO) && (addr_w <= HI);

endmodule

// File: rtl/gcs_decoder.sv
module gcs_decoder
    import gcs_pkg::*;
#(
    parameter int unsigned RAM_BYTES   = 32'h0001_0000,
    parameter int unsigned FLASH_BYTES = 32'h0010_0000,
    parameter int unsigned HIDE_BASE   = 32'h0010_0000,
    parameter int unsigned HIDE_BYTES  = 32'h0004_0000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [2:0]        mode_i,
    input  logic              rom_hide_i,
    input  logic              nvm_on_i,
    input  logic              reg_wr_i,
    input  logic [CTRL_W-1:0] reg_wdata_i,
    output logic [CTRL_W-1:0] reg_rdata_o,
    input  logic              acc_valid_i,
    input  logic [GA_W-1:0]   acc_addr_i,
    output logic [NUM_CS-1:0] cs_n_o
);

    localparam int unsigned HIDE_TOP  = HIDE_BASE + HIDE_BYTES - 1;
    localparam int unsigned RAM_LO    = CS3_CEIL - RAM_BYTES + 1;
    localparam int unsigned FLASH_LO  = CS0_CEIL - FLASH_BYTES + 1;

    bus_acc_t          acc;
    mode_ctl_t         mctl;
    logic [NUM_CS-1:0] field_en;
    logic [NUM_CS-1:0] win_hit;
    logic [NUM_CS-1:0] sel;
    logic              cs0_full_hit;
    logic              hide_hit;
    logic [NUM_CS-1:0] cs_n_q;

    assign acc.valid     = acc_valid_i;
    assign acc.addr      = acc_addr_i;
    assign mctl.hide     = rom_hide_i;
    assign mctl.nvm      = nvm_on_i;
    assign mctl.expanded = mode_is_expanded(mode_i);

    gcs_ctrl_reg u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .q_o     (reg_rdata_o),
        .en_o    (field_en)
    );

    // trimmed windows, one per chip select
    for (genvar i = 0; i < NUM_CS; i++) begin : g_win
        gcs_window #(
            .LO (win_lo(i)),
            .HI (win_hi(i, RAM_BYTES, FLASH_BYTES))
        ) u_win (
            .addr_i (acc.addr),
            .hit_o  (win_hit[i])
        );
    end

    // chip select 0 without the flash trim
    gcs_window #(
        .LO (CS0_LO),
        .HI (CS0_CEIL)
    ) u_cs0_full (
        .addr_i (acc.addr),
        .hit_o  (cs0_full_hit)
    );

    // region that the hide control lends to chip select 2
    gcs_window #(
        .LO (HIDE_BASE),
        .HI (HIDE_TOP)
    ) u_hide (
        .addr_i (acc.addr),
        .hit_o  (hide_hit)
    );

    always_comb begin
        sel    = win_hit;
        sel[0] = mctl.nvm ? win_hit[0] : cs0_full_hit;
        sel[2] = win_hit[2] | (mctl.hide & hide_hit);
        sel    = sel & field_en & {NUM_CS{acc.valid & mctl.expanded}};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cs_n_q <= '1;
        end else begin
            cs_n_q <= ~sel;
        end
    end

    assign cs_n_o = cs_n_q;

    assert_idle_no_valid_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !acc_valid_i |=> (cs_n_o == '1));

    assert_exclusive_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(~cs_n_o));

    assert_mode_gate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !mode_is_expanded(mode_i) |=> (cs_n_o == '1));

    assert_ram_gap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (32'(acc_addr_i) >= RAM_LO && 32'(acc_addr_i) <= CS3_CEIL) |=> cs_n_o[3]);

    assert_flash_guard_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (nvm_on_i && 32'(acc_addr_i) >= FLASH_LO) |=> cs_n_o[0]);

    assert_cs1_outside_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (32'(acc_addr_i) < CS1_LO || 32'(acc_addr_i) > CS1_HI) |=> cs_n_o[1]);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_chk
        assert_field_off_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            (reg_rdata_o[FIELD_W*i +: FIELD_W] == 2'b00) |=> cs_n_o[i]);
    end

endmodule

// File: tb/gcs_decoder_test.sv
module gcs_decoder_test;

    localparam int unsigned RAM_B   = 32'h0001_0000;
    localparam int unsigned FLASH_B = 32'h0010_0000;
    localparam int unsigned HBASE   = 32'h0010_0000;
    localparam int unsigned HBYTES  = 32'h0004_0000;
    localparam int NADDR = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'd0;
    logic        hide = 1'b0;
    logic        nvm = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        valid = 1'b0;
    logic [22:0] addr = '0;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gcs_decoder #(
        .RAM_BYTES   (RAM_B),
        .FLASH_BYTES (FLASH_B),
        .HIDE_BASE   (HBASE),
        .HIDE_BYTES  (HBYTES)
    ) uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .mode_i      (mode),
        .rom_hide_i  (hide),
        .nvm_on_i    (nvm),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .acc_valid_i (valid),
        .acc_addr_i  (addr),
        .cs_n_o      (cs_n)
    );

    always #4 clk = ~clk;

    // reference model state
    logic [7:0] model_reg = 8'h00;
    logic [3:0] exp_cs = 4'hF;
    string      exp_tag = "R11";
    bit         have_exp = 1'b0;

    function automatic logic [3:0] ref_window(input int unsigned a, input bit h, input bit n);
        logic [3:0] s;
        s[3] = (a >= 32'h800) && (a <= 32'hF_FFFF - RAM_B);                     // R4
        s[2] = ((a >= 32'h14_0000) && (a <= 32'h1F_FFFF)) ||                    // R5
               (h && (a >= HBASE) && (a < HBASE + HBYTES));                     // R6
        s[1] = (a >= 32'h20_0000) && (a <= 32'h3F_FFFF);                        // R7
        s[0] = (a >= 32'h40_0000) &&
               (a <= (n ? 32'h7F_FFFF - FLASH_B : 32'h7F_FFFF));                // R8 / R9
        return s;
    endfunction

    function automatic string pick_tag(input int unsigned a);
        if (rst) return "R11";
        if (wr) return "R11";
        if (!valid) return "R10";
        if (!(mode == 3'd3 || mode == 3'd5)) return "R3";
        if (hide && a >= HBASE && a < HBASE + HBYTES) return "R6";
        if (a >= 32'h40_0000) return nvm ? "R8" : "R9";
        if (a >= 32'h20_0000) return (model_reg[3:2] == 2'b00) ? "R2" : "R7";
        if (a >= 32'h14_0000) return (model_reg[5:4] == 2'b00) ? "R2" : "R5";
        return (model_reg[7:6] == 2'b00) ? "R2" : "R4";
    endfunction

    always @(posedge clk) begin
        logic [3:0] s;
        logic [3:0] en;
        exp_tag = pick_tag(32'(addr));
        if (rst) begin
            exp_cs    = 4'hF;
            model_reg = 8'h00;
        end else begin
            s  = ref_window(32'(addr), hide, nvm);
            en = {|model_reg[7:6], |model_reg[5:4], |model_reg[3:2], |model_reg[1:0]};
            if (valid && (mode == 3'd3 || mode == 3'd5))
                exp_cs = ~(s & en);
            else
                exp_cs = 4'hF;
            if (wr) model_reg = wdata;
        end
        have_exp = 1'b1;
    end

    always @(negedge clk) begin
        if (have_exp && !done) begin
            checks++;
            if (cs_n !== exp_cs) begin
                errors++;
                $display("FAIL %s cs_n actual=%b expected=%b addr=%h mode=%0d hide=%0b nvm=%0b reg=%h",
                         exp_tag, cs_n, exp_cs, addr, mode, hide, nvm, model_reg);
            end
            checks++;
            if (rdata !== model_reg) begin
                errors++;
                $display("FAIL R1 rdata actual=%h expected=%h", rdata, model_reg);
            end
        end
    end

    task automatic step(input bit v, input logic [22:0] a, input bit w, input logic [7:0] d);
        @(negedge clk);
        valid = v;
        addr  = a;
        wr    = w;
        wdata = d;
    endtask

    int unsigned probe [NADDR];
    logic [7:0]  en_pat [6];

    initial begin
        probe[0]  = 32'h0;
        probe[1]  = 32'h7FF;
        probe[2]  = 32'h800;
        probe[3]  = 32'hF_FFFF - RAM_B;
        probe[4]  = 32'hF_FFFF - RAM_B + 1;
        probe[5]  = HBASE - 1;
        probe[6]  = HBASE;
        probe[7]  = HBASE + HBYTES - 1;
        probe[8]  = HBASE + HBYTES;
        probe[9]  = 32'h1F_FFFF;
        probe[10] = 32'h20_0000;
        probe[11] = 32'h3F_FFFF;
        probe[12] = 32'h40_0000;
        probe[13] = 32'h7F_FFFF - FLASH_B;
        probe[14] = 32'h7F_FFFF - FLASH_B + 1;
        probe[15] = 32'h7F_FFFF;
        // R2: mixes of 00 with each of 01, 10, 11
        en_pat[0] = 8'h00;
        en_pat[1] = 8'hFF;
        en_pat[2] = 8'h55;
        en_pat[3] = 8'hAA;
        en_pat[4] = 8'h1B;
        en_pat[5] = 8'hE4;

        // R11: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mode = 3'd5;
        step(1'b0, '0, 1'b0, 8'h00);
        step(1'b1, 23'h20_0000, 1'b0, 8'h00);
        // R11: write and access together use the old value, then the new one
        step(1'b1, 23'h20_0000, 1'b1, 8'h0C);
        step(1'b1, 23'h20_0000, 1'b0, 8'h00);
        step(1'b0, 23'h20_0000, 1'b0, 8'h00);   // R10 idle

        for (int e = 0; e < 6; e++) begin
            step(1'b0, '0, 1'b1, en_pat[e]);
            for (int m = 0; m < 8; m++) begin
                for (int hn = 0; hn < 4; hn++) begin
                    mode = 3'(m);
                    hide = hn[0];
                    nvm  = hn[1];
                    for (int k = 0; k < NADDR; k++) begin
                        step(1'b1, 23'(probe[k]), 1'b0, 8'h00);
                    end
                    step(1'b0, 23'(probe[10]), 1'b0, 8'h00);
                end
            end
        end

        // R11: mid-run reset clears the register
        step(1'b1, 23'h30_0000, 1'b0, 8'h00);
        rst = 1'b1;
        step(1'b1, 23'h30_0000, 1'b0, 8'h00);
        rst = 1'b0;
        step(1'b1, 23'h30_0000, 1'b0, 8'h00);
        step(1'b0, '0, 1'b0, 8'h00);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule